// File: doc/BRIEF.md
# Mailbox Aperture with Ownership Handoff

This block is a small register window shared by two agents: a requester and a responder. The window is eight 32-bit words. Each side has its own write port and its own read port, and the reads are combinational. One flag decides which side may write at any moment. That flag is bit 31 of the last word.

The requester fills the payload words. Its write to the last word (the header word) passes the window to the responder. The responder may then update any word. When it writes the header word with bit 31 clear, the window goes back to the requester. A write from the side that does not own the window is dropped. A requester write dropped this way also raises a sticky error flag.

While reset is held, both read ports return all ones. This gives the other side a pattern it can recognise. After reset is released, the window holds zeros and the requester owns it.

Header word layout: message type in bits 2:0, version in bits 5:3, direction in bit 7 (0 request, 1 response), status in bits 15:8, reset request in bit 24, owner flag in bit 31. The block acts only on bit 31; all other bits are stored as written.

Top module: `mbox_handoff`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both read ports return 0xFFFFFFFF for every word address after that edge.
- R2: At the first edge after `rst_n` goes high, every word reads 0x00000000 on both ports, `owner_rsp` is 0 and `req_err` is 0.
- R3: A requester write to words 0..6 while `owner_rsp` is 0 stores the data. The data is visible on both read ports after the next rising edge.
- R4: A requester write to word 7 while `owner_rsp` is 0 stores the data with bit 31 forced to 1. `owner_rsp` becomes 1 after that edge.
- R5: A requester write while `owner_rsp` is 1 leaves all words unchanged and sets `req_err`. `req_err` then stays 1 until reset.
- R6: A responder write while `owner_rsp` is 1 stores the data as given. If the write targets word 7, `owner_rsp` takes the value of bit 31 of the written data: 0 returns the window to the requester and 1 keeps it with the responder.
- R7: A responder write while `owner_rsp` is 0 leaves all words unchanged and leaves `req_err` unchanged.
- R8: Words 0..6 keep their contents when ownership moves in either direction.
- R9: When both sides write in the same cycle, only the owner's write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_wr_en | input | 1 | Requester write strobe |
| req_wr_addr | input | 3 | Requester write word address |
| req_wr_data | input | 32 | Requester write data |
| req_rd_addr | input | 3 | Requester read word address |
| req_rd_data | output | 32 | Requester read data (combinational) |
| rsp_wr_en | input | 1 | Responder write strobe |
| rsp_wr_addr | input | 3 | Responder write word address |
| rsp_wr_data | input | 32 | Responder write data |
| rsp_rd_addr | input | 3 | Responder read word address |
| rsp_rd_data | output | 32 | Responder read data (combinational) |
| owner_rsp | output | 1 | 1 when the responder owns the window |
| req_err | output | 1 | Sticky flag for dropped requester writes |

## Verification
The bench builds the block with its default of eight words. With this size the header word is word 7 and a 3-bit address reaches every word. That covers the handoff on the last word, the payload words that must survive each transfer, and the boundary between the two.

A reference shadow of all eight words is updated from the requirement rules. Every word is compared on both read ports after each step. The steps include dropped writes from each side, writes from both sides in the same cycle, and a second reset taken while the responder owns the window.

// File: rtl/mbox_pkg.sv
// Package: shared word and header types for the mailbox aperture.
// Assumes a 32-bit word; the owner flag position comes from the header layout.
package mbox_pkg;

    typedef logic [31:0] word_t;

    // Header word layout; only the owner field is acted upon by hardware.
    typedef struct packed {
        logic       owner;      // 31: 1 = responder owns
        logic [5:0] rsvd_hi;    // 30:25
        logic       reset_req;  // 24
        logic [7:0] rsvd_mid;   // 23:16
        logic [7:0] status;     // 15:8
        logic       direction;  // 7: 0 request, 1 response
        logic       rsvd_lo;    // 6
        logic [2:0] version;    // 5:3
        logic [2:0] msg_kind;   // 2:0
    } hdr_t;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned OWNER_POS = 31;

    // Return a header word with the owner flag set to the responder.
    function automatic word_t claim_for_responder(input word_t w);
        hdr_t h;
        h       = hdr_t'(w);
        h.owner = 1'b1;
        return word_t'(h);
    endfunction

endpackage

// File: rtl/mbox_access_gate.sv
// Module: mbox_access_gate
// Decides which write strobe is accepted, from the current owner flag, and
// keeps the sticky flag for requester writes that arrive while the responder
// owns the window. Assumes the owner flag is a registered value from the bank.
module mbox_access_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic owner,
    input  logic req_wr_en,
    input  logic rsp_wr_en,
    output logic req_accept,
    output logic rsp_accept,
    output logic req_err
);

    // Accept only the strobe of the side that currently owns the window.
    always_comb begin
        req_accept = req_wr_en && !owner;
        rsp_accept = rsp_wr_en &&  owner;
    end

    // Sticky error: set on any dropped requester write, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_err <= 1'b0;
        end else if (req_wr_en && owner) begin
            req_err <= 1'b1;
        end
    end

    a_r5_err_on_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr_en && owner) |=> req_err);

    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> req_err);

endmodule

// File: rtl/mbox_dword_bank.sv
// Module: mbox_dword_bank
// Storage for the aperture words. The owner flag is a bit of the last word.
// Reset clears every word and raises a blanking flag, which makes the read
// ports return all ones until the first edge after reset is released.
// Assumes that at most one accept strobe is high in any cycle.
module mbox_dword_bank #(
    parameter int unsigned NUM_WORDS = 8,
    localparam int unsigned AW   = $clog2(NUM_WORDS),
    localparam int unsigned LAST = NUM_WORDS - 1,
    localparam int unsigned W    = mbox_pkg::WORD_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_accept,
    input  logic [AW-1:0]          req_addr,
    input  logic [W-1:0]           req_data,
    input  logic                   rsp_accept,
    input  logic [AW-1:0]          rsp_addr,
    input  logic [W-1:0]           rsp_data,
    output logic [NUM_WORDS*W-1:0] words_flat,
    output logic                   blank,
    output logic                   owner
);

    logic [W-1:0] words [NUM_WORDS];
    logic [W-1:0] req_last_word;

    // Requester data bound for the header word gets the owner flag set.
    always_comb req_last_word = mbox_pkg::claim_for_responder(req_data);

    // Blanking flag: high from a reset edge until the first edge out of reset.
    always_ff @(posedge clk) begin
        blank <= !rst_n;
    end

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        localparam logic [AW-1:0] IDX = AW'(i);

        // Word i: clear on reset, else take the accepted write aimed at it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[i] <= '0;
            end else if (rsp_accept && rsp_addr == IDX) begin
                words[i] <= rsp_data;
            end else if (req_accept && req_addr == IDX) begin
                words[i] <= (i == LAST) ? req_last_word : req_data;
            end
        end

        assign words_flat[i*W +: W] = words[i];
    end

    assign owner = words[LAST][mbox_pkg::OWNER_POS];

    a_r4_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && req_addr == AW'(LAST)) |=> owner);

    a_r6_return: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_accept && rsp_addr == AW'(LAST) && !rsp_data[mbox_pkg::OWNER_POS])
        |=> !owner);

    a_r6_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_accept && rsp_addr == AW'(LAST) && rsp_data[mbox_pkg::OWNER_POS])
        |=> owner);

    a_r7_owner_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_accept && !req_accept) |=> $stable(owner));

endmodule

// File: rtl/mbox_read_port.sv
// Module: mbox_read_port
// Combinational word select for one side; returns all ones while blanked.
// Assumes the address is always below the word count.
module mbox_read_port #(
    parameter int unsigned NUM_WORDS = 8,
    localparam int unsigned AW = $clog2(NUM_WORDS),
    localparam int unsigned W  = mbox_pkg::WORD_W
) (
    input  logic                   blank,
    input  logic [NUM_WORDS*W-1:0] words_flat,
    input  logic [AW-1:0]          rd_addr,
    output logic [W-1:0]           rd_data
);

    // Select the addressed word, or the reset pattern while blanked.
    always_comb begin
        if (blank) begin
            rd_data = '1;
        end else begin
            rd_data = words_flat[rd_addr*W +: W];
        end
    end

endmodule

// File: rtl/mbox_handoff.sv
// Module: mbox_handoff (top)
// A shared word window with a single owner flag held in the header word.
// A requester write to the header word passes the window to the responder.
// A responder write to the header word with the owner bit clear passes it back.
// Assumes synchronous active-low reset and one clock for both sides.
module mbox_handoff #(
    parameter int unsigned NUM_WORDS = 8,
    localparam int unsigned AW = $clog2(NUM_WORDS),
    localparam int unsigned W  = mbox_pkg::WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_wr_en,
    input  logic [AW-1:0] req_wr_addr,
    input  logic [W-1:0]  req_wr_data,
    input  logic [AW-1:0] req_rd_addr,
    output logic [W-1:0]  req_rd_data,
    input  logic          rsp_wr_en,
    input  logic [AW-1:0] rsp_wr_addr,
    input  logic [W-1:0]  rsp_wr_data,
    input  logic [AW-1:0] rsp_rd_addr,
    output logic [W-1:0]  rsp_rd_data,
    output logic          owner_rsp,
    output logic          req_err
);

    logic                   req_accept;
    logic                   rsp_accept;
    logic                   blank;
    logic                   owner;
    logic [NUM_WORDS*W-1:0] words_flat;

    mbox_access_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .owner      (owner),
        .req_wr_en  (req_wr_en),
        .rsp_wr_en  (rsp_wr_en),
        .req_accept (req_accept),
        .rsp_accept (rsp_accept),
        .req_err    (req_err)
    );

    mbox_dword_bank #(.NUM_WORDS(NUM_WORDS)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_accept (req_accept),
        .req_addr   (req_wr_addr),
        .req_data   (req_wr_data),
        .rsp_accept (rsp_accept),
        .rsp_addr   (rsp_wr_addr),
        .rsp_data   (rsp_wr_data),
        .words_flat (words_flat),
        .blank      (blank),
        .owner      (owner)
    );

    mbox_read_port #(.NUM_WORDS(NUM_WORDS)) u_rd_req (
        .blank      (blank),
        .words_flat (words_flat),
        .rd_addr    (req_rd_addr),
        .rd_data    (req_rd_data)
    );

    mbox_read_port #(.NUM_WORDS(NUM_WORDS)) u_rd_rsp (
        .blank      (blank),
        .words_flat (words_flat),
        .rd_addr    (rsp_rd_addr),
        .rd_data    (rsp_rd_data)
    );

    assign owner_rsp = owner;

    // R9: the two accept strobes never fire together.
    a_r9_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_accept && rsp_accept));

endmodule

// File: tb/mbox_handoff_tb.sv
module mbox_handoff_tb;

    localparam int NW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_wr_en = 1'b0, rsp_wr_en = 1'b0;
    logic [2:0]  req_wr_addr = '0, rsp_wr_addr = '0;
    logic [2:0]  req_rd_addr = '0, rsp_rd_addr = '0;
    logic [31:0] req_wr_data = '0, rsp_wr_data = '0;
    logic [31:0] req_rd_data, rsp_rd_data;
    logic        owner_rsp, req_err;

    always #4 clk = ~clk;   // 125 MHz

    mbox_handoff u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_wr_en(req_wr_en), .req_wr_addr(req_wr_addr), .req_wr_data(req_wr_data),
        .req_rd_addr(req_rd_addr), .req_rd_data(req_rd_data),
        .rsp_wr_en(rsp_wr_en), .rsp_wr_addr(rsp_wr_addr), .rsp_wr_data(rsp_wr_data),
        .rsp_rd_addr(rsp_rd_addr), .rsp_rd_data(rsp_rd_data),
        .owner_rsp(owner_rsp), .req_err(req_err)
    );

    // Scoreboard item: kind 0 = requester read, 1 = responder read,
    // 2 = owner flag, 3 = error flag.
    typedef struct {
        int          kind;
        int          addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       q[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    logic [31:0] shadow [NW];
    logic        exp_err = 1'b0;

    // Driver side: push one expectation.
    task automatic expect_item(input int kind, input int addr,
                               input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.addr = addr; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    // Push every word on both ports plus both flags, then wait for the monitor.
    task automatic check_all(input string tag);
        for (int i = 0; i < NW; i++) begin
            expect_item(0, i, shadow[i], tag);
            expect_item(1, i, shadow[i], tag);
        end
        expect_item(2, 0, {31'd0, shadow[NW-1][31]}, tag);
        expect_item(3, 0, {31'd0, exp_err}, tag);
        wait (q.size() == 0);
    endtask

    task automatic check_ones(input string tag);
        for (int i = 0; i < NW; i++) begin
            expect_item(0, i, 32'hFFFF_FFFF, tag);
            expect_item(1, i, 32'hFFFF_FFFF, tag);
        end
        wait (q.size() == 0);
    endtask

    // Shadow update from the requirement rules.
    function automatic void model_req(input int a, input logic [31:0] d);
        if (!shadow[NW-1][31]) shadow[a] = (a == NW-1) ? (d | 32'h8000_0000) : d;
        else exp_err = 1'b1;
    endfunction

    function automatic void model_rsp(input int a, input logic [31:0] d);
        if (shadow[NW-1][31]) shadow[a] = d;
    endfunction

    task automatic do_write(input bit rq, input bit rs, input int a_rq,
                            input logic [31:0] d_rq, input int a_rs,
                            input logic [31:0] d_rs);
        @(negedge clk);
        req_wr_en = rq; req_wr_addr = 3'(a_rq); req_wr_data = d_rq;
        rsp_wr_en = rs; rsp_wr_addr = 3'(a_rs); rsp_wr_data = d_rs;
        @(negedge clk);
        req_wr_en = 1'b0; rsp_wr_en = 1'b0;
        // Both rules are judged on the owner before the edge.
        begin
            logic own_before;
            own_before = shadow[NW-1][31];
            if (rq && !own_before) model_req(a_rq, d_rq);
            else if (rq) exp_err = 1'b1;
            if (rs && own_before) shadow[a_rs] = d_rs;
        end
    endtask

    // Monitor: one item per cycle, sampled 2 ns after the rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                req_rd_addr = 3'(it.addr);
                rsp_rd_addr = 3'(it.addr);
                #1;
                case (it.kind)
                    0: act = req_rd_data;
                    1: act = rsp_rd_data;
                    2: act = {31'd0, owner_rsp};
                    default: act = {31'd0, req_err};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d addr=%0d actual=%h expected=%h",
                             it.tag, it.kind, it.addr, act, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NW; i++) shadow[i] = '0;
        // R1: all ones while reset is held.
        repeat (2) @(negedge clk);
        check_ones("R1 reset readback");
        // R2: zeros and requester ownership after release.
        @(negedge clk); rst_n = 1'b1;
        check_all("R2 after reset");
        // R3: payload writes by the requester.
        for (int i = 0; i < NW-1; i++)
            do_write(1, 0, i, 32'h1111_0000 * (i + 1) + 32'(i), 0, 0);
        check_all("R3 payload");
        // R4: header write hands over, bit 31 forced.
        do_write(1, 0, 7, 32'h0100_0001, 0, 0);
        check_all("R4 handoff");
        // R5: requester write while the responder owns.
        do_write(1, 0, 2, 32'hDEAD_BEEF, 0, 0);
        check_all("R5 blocked write");
        // R9: both write, responder owns.
        do_write(1, 1, 4, 32'hAAAA_AAAA, 4, 32'h5555_5555);
        check_all("R9 responder wins");
        // R6: header with bit 31 set keeps responder ownership.
        do_write(0, 1, 0, 0, 7, 32'h8000_0181);
        check_all("R6 keep");
        // R6/R8: header with bit 31 clear returns ownership, payload intact.
        do_write(0, 1, 0, 0, 7, 32'h0000_0081);
        check_all("R6 R8 return");
        // R7: responder write while the requester owns.
        do_write(0, 1, 0, 0, 1, 32'h0BAD_0BAD);
        check_all("R7 blocked responder");
        // R9: both write, requester owns.
        do_write(1, 1, 5, 32'h1234_5678, 5, 32'h8765_4321);
        check_all("R9 requester wins");
        // R4: header with bit 31 clear from the requester is still a handoff.
        do_write(1, 0, 7, 32'h0000_0002, 0, 0);
        check_all("R4 R8 second handoff");
        // R1/R2: reset while the responder owns.
        @(negedge clk); rst_n = 1'b0;
        for (int i = 0; i < NW; i++) shadow[i] = '0;
        exp_err = 1'b0;
        @(negedge clk);
        check_ones("R1 second reset");
        @(negedge clk); rst_n = 1'b1;
        check_all("R2 second release");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule